// File: doc/BRIEF.md
# DFI phase-rate down-converter

This block sits between a memory controller that issues DFI traffic on a wide, slow interface and a PHY that takes DFI traffic on a narrower interface clocked RATIO times faster. The controller side offers N_PH×RATIO phases per slow period; the PHY side offers N_PH phases per fast cycle. The slow clock is modelled as a one-cycle strobe, `slow_tick`, that the surrounding logic raises in the last fast cycle of every slow period, so the whole block runs on the single fast clock.

On each strobe the block captures one slow period of wide-side traffic. Over the next RATIO fast cycles (called slots 0 to RATIO−1) it spreads the commands out in time, N_PH phases per slot. Write data and masks travel differently. RATIO adjacent wide phases are concatenated into one narrow phase, and the whole packed word goes out in one chosen slot. Read data returning on the narrow side is captured in one chosen slot. It is split back into wide phases, and the result is shown on the wide side for the whole next slow period. Two delay parameters choose these slots, so that PHY latencies that are not a multiple of RATIO can still line up.

Top module: `dfi_rate_down`

## Requirements
- R1: A command on wide phase k, captured at a strobe edge, drives narrow phase k mod N_PH during slot floor(k/N_PH). Slot 0 is the fast cycle right after that edge. The fields chip-select, row strobe, column strobe, write enable, bank, address and write-data enable are copied unchanged.
- R2: The idle value is chip-select, row strobe, column strobe and write enable all 1, with the write-data enable at 0. A narrow phase takes this value while no slot is active, which is the case from reset until the first strobe and after slot RATIO−1 until the next strobe.
- R3: The write data of narrow phase j is wide phases j·RATIO through j·RATIO+RATIO−1, concatenated with the lowest wide phase in the least significant bits. For example, 0x11, 0x22, 0x33 and 0x44 give 0x44332211.
- R4: Write masks are packed in the same order as write data.
- R5: Packed write data and masks for all narrow phases appear only in slot WR_DLY. In every other cycle they are zero.
- R6: Narrow read data is sampled in slot RD_DLY. Narrow phase j is split into wide phases j·RATIO upward, starting from the low slice.
- R7: The read-valid bit of narrow phase j is copied to all RATIO wide phases of its group.
- R8: Wide-side read data and valid bits change only on the edge that follows a strobe, and hold for the whole slow period after it.
- R9: The PHY-side reset level equals the wide-side reset level captured at the last strobe. It reads 0 until the first strobe.
- R10: While reset is asserted, every narrow phase is idle, write data and masks are zero, and wide read data and valid bits are zero.
- R11: Wide-side inputs that change in cycles without the strobe have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous reset, active high |
| slow_tick | input | 1 | Slow-period strobe, high in the last fast cycle of a period |
| in_reset_n | input | 1 | Wide-side DRAM reset level |
| w_cs_n | input | NW | Wide chip-select per phase, active low |
| w_ras_n | input | NW | Wide row strobe per phase |
| w_cas_n | input | NW | Wide column strobe per phase |
| w_we_n | input | NW | Wide write enable per phase |
| w_bank | input | NW*BBITS | Wide bank address, phase k at bits k*BBITS |
| w_addr | input | NW*ABITS | Wide row/column address, phase k at bits k*ABITS |
| w_wren | input | NW | Wide write-data enable per phase |
| w_wrdata | input | NW*WDW | Wide write data, phase k at bits k*WDW |
| w_wrmask | input | NW*WMW | Wide write mask, phase k at bits k*WMW |
| w_rddata | output | NW*WDW | Wide read data, phase k at bits k*WDW |
| w_rdvalid | output | NW | Wide read valid per phase |
| out_reset_n | output | 1 | PHY-side DRAM reset level |
| n_cs_n | output | N_PH | Narrow chip-select per phase |
| n_ras_n | output | N_PH | Narrow row strobe per phase |
| n_cas_n | output | N_PH | Narrow column strobe per phase |
| n_we_n | output | N_PH | Narrow write enable per phase |
| n_bank | output | N_PH*BBITS | Narrow bank address |
| n_addr | output | N_PH*ABITS | Narrow address |
| n_wren | output | N_PH | Narrow write-data enable |
| n_wrdata | output | N_PH*NDW | Packed write data, phase j at bits j*NDW |
| n_wrmask | output | N_PH*NMW | Packed write mask, phase j at bits j*NMW |
| n_rddata | input | N_PH*NDW | PHY read data, phase j at bits j*NDW |
| n_rdvalid | input | N_PH | PHY read valid per phase |

## Verification
Some properties are checked by assertions on every cycle. A strobe always starts slot 0. Narrow control is idle whenever no slot is active. Write data and masks are non-zero only in slot WR_DLY. Wide read outputs stay frozen except after a strobe. Reset leaves everything idle. Other behaviour shows up only in the bench's scenarios, where a cycle-level reference model is compared on every clock: the exact phase each command lands on, the byte order of packing and unpacking, the copying of read-valid bits, the capture slot for read data (including the case where it coincides with the strobe), and the fact that off-strobe input changes are ignored.

// File: rtl/dfi_rd_pkg.sv
package dfi_rd_pkg;

  // Control nibble order inside a command word: {we_n, cas_n, ras_n, cs_n}
  localparam logic [3:0] CTL_IDLE = 4'b1111;

  function automatic int slot_of(input int k, input int nph);
    return k / nph;
  endfunction

  function automatic int lane_of(input int k, input int nph);
    return k % nph;
  endfunction

  function automatic int wide_idx(input int slot, input int lane, input int nph);
    return slot * nph + lane;
  endfunction

  function automatic int slot_bits(input int ratio);
    return $clog2(ratio + 1);
  endfunction

endpackage

// File: rtl/dfi_rd_slot_ctr.sv
module dfi_rd_slot_ctr #(
  parameter int RATIO = 4,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  output logic [CW-1:0] slot,
  output logic          active
);
  localparam logic [CW-1:0] SLOT_OFF = CW'(RATIO);

  always_ff @(posedge clk) begin
    if (rst)                   slot <= SLOT_OFF;
    else if (tick)             slot <= '0;
    else if (slot != SLOT_OFF) slot <= slot + 1'b1;
  end

  assign active = (slot != SLOT_OFF);
endmodule

// File: rtl/dfi_rd_cmd_ser.sv
module dfi_rd_cmd_ser
  import dfi_rd_pkg::*;
#(
  parameter int N_PH  = 2,
  parameter int RATIO = 4,
  parameter int CMDW  = 24,
  parameter int CW    = 3,
  parameter logic [CMDW-1:0] IDLE = '0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tick,
  input  logic [N_PH*RATIO*CMDW-1:0] wide_cmd,
  input  logic [CW-1:0]          slot,
  input  logic                   active,
  output logic [N_PH*CMDW-1:0]   nar_cmd
);
  localparam int NW = N_PH * RATIO;

  logic [NW*CMDW-1:0] cap;

  always_ff @(posedge clk) begin
    if (rst)       cap <= {NW{IDLE}};
    else if (tick) cap <= wide_cmd;
  end

  logic [CW-1:0] sel;
  assign sel = active ? slot : '0;

  for (genvar j = 0; j < N_PH; j++) begin : g_lane
    always_comb begin
      nar_cmd[j*CMDW +: CMDW] = IDLE;
      if (active)
        nar_cmd[j*CMDW +: CMDW] = cap[wide_idx(int'(sel), j, N_PH)*CMDW +: CMDW];
    end
  end
endmodule

// File: rtl/dfi_rd_wr_pack.sv
module dfi_rd_wr_pack #(
  parameter int TOTW   = 64,
  parameter int WR_DLY = 0,
  parameter int CW     = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic [TOTW-1:0] wide_in,
  input  logic [CW-1:0]   slot,
  input  logic            active,
  output logic            launch,
  output logic [TOTW-1:0] nar_out
);
  // Wide phase k sits at slice k; narrow phase j spans slices j*RATIO upward,
  // so low-phase-first packing keeps the flat bit order.
  logic [TOTW-1:0] cap;

  always_ff @(posedge clk) begin
    if (rst)       cap <= '0;
    else if (tick) cap <= wide_in;
  end

  assign launch  = active && (slot == CW'(WR_DLY));
  assign nar_out = launch ? cap : '0;
endmodule

// File: rtl/dfi_rd_rd_unpack.sv
module dfi_rd_rd_unpack #(
  parameter int N_PH   = 2,
  parameter int RATIO  = 4,
  parameter int NDW    = 32,
  parameter int RD_DLY = 0,
  parameter int CW     = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick,
  input  logic [CW-1:0]           slot,
  input  logic                    active,
  input  logic [N_PH*NDW-1:0]     nar_data,
  input  logic [N_PH-1:0]         nar_valid,
  output logic                    grab,
  output logic [N_PH*NDW-1:0]     wide_data,
  output logic [N_PH*RATIO-1:0]   wide_valid
);
  logic [N_PH*NDW-1:0] stage_d, next_d, hold_d;
  logic [N_PH-1:0]     stage_v, next_v, hold_v;

  assign grab   = active && (slot == CW'(RD_DLY));
  assign next_d = grab ? nar_data  : stage_d;
  assign next_v = grab ? nar_valid : stage_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_d <= '0;
      stage_v <= '0;
      hold_d  <= '0;
      hold_v  <= '0;
    end else begin
      if (grab) begin
        stage_d <= nar_data;
        stage_v <= nar_valid;
      end
      if (tick) begin
        hold_d <= next_d;
        hold_v <= next_v;
      end
    end
  end

  assign wide_data = hold_d;
  for (genvar p = 0; p < N_PH*RATIO; p++) begin : g_valid
    assign wide_valid[p] = hold_v[p / RATIO];
  end
endmodule

// File: rtl/dfi_rate_down.sv
module dfi_rate_down
  import dfi_rd_pkg::*;
#(
  parameter int N_PH   = 2,
  parameter int RATIO  = 4,
  parameter int ABITS  = 16,
  parameter int BBITS  = 3,
  parameter int NDW    = 32,
  parameter int WR_DLY = 0,
  parameter int RD_DLY = 0,
  localparam int NW    = N_PH * RATIO,
  localparam int WDW   = NDW / RATIO,
  localparam int NMW   = NDW / 8,
  localparam int WMW   = NMW / RATIO
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  slow_tick,
  input  logic                  in_reset_n,
  input  logic [NW-1:0]         w_cs_n,
  input  logic [NW-1:0]         w_ras_n,
  input  logic [NW-1:0]         w_cas_n,
  input  logic [NW-1:0]         w_we_n,
  input  logic [NW*BBITS-1:0]   w_bank,
  input  logic [NW*ABITS-1:0]   w_addr,
  input  logic [NW-1:0]         w_wren,
  input  logic [NW*WDW-1:0]     w_wrdata,
  input  logic [NW*WMW-1:0]     w_wrmask,
  output logic [NW*WDW-1:0]     w_rddata,
  output logic [NW-1:0]         w_rdvalid,
  output logic                  out_reset_n,
  output logic [N_PH-1:0]       n_cs_n,
  output logic [N_PH-1:0]       n_ras_n,
  output logic [N_PH-1:0]       n_cas_n,
  output logic [N_PH-1:0]       n_we_n,
  output logic [N_PH*BBITS-1:0] n_bank,
  output logic [N_PH*ABITS-1:0] n_addr,
  output logic [N_PH-1:0]       n_wren,
  output logic [N_PH*NDW-1:0]   n_wrdata,
  output logic [N_PH*NMW-1:0]   n_wrmask,
  input  logic [N_PH*NDW-1:0]   n_rddata,
  input  logic [N_PH-1:0]       n_rdvalid
);
  localparam int CW   = slot_bits(RATIO);
  localparam int CMDW = 4 + BBITS + ABITS + 1;
  localparam logic [CMDW-1:0] CMD_IDLE = {{(CMDW-4){1'b0}}, CTL_IDLE};

  // Named internal events used by the checker
  logic [CW-1:0] slot;
  logic          active;
  logic          wr_launch;
  logic          mask_launch;
  logic          rd_grab;

  dfi_rd_slot_ctr #(.RATIO(RATIO), .CW(CW)) u_ctr (
    .clk(clk), .rst(rst), .tick(slow_tick), .slot(slot), .active(active)
  );

  logic [NW*CMDW-1:0]   wcmd;
  logic [N_PH*CMDW-1:0] ncmd;

  for (genvar k = 0; k < NW; k++) begin : g_wcmd
    assign wcmd[k*CMDW +: CMDW] = {w_wren[k], w_addr[k*ABITS +: ABITS],
                                   w_bank[k*BBITS +: BBITS], w_we_n[k],
                                   w_cas_n[k], w_ras_n[k], w_cs_n[k]};
  end

  dfi_rd_cmd_ser #(
    .N_PH(N_PH), .RATIO(RATIO), .CMDW(CMDW), .CW(CW), .IDLE(CMD_IDLE)
  ) u_cmd (
    .clk(clk), .rst(rst), .tick(slow_tick), .wide_cmd(wcmd),
    .slot(slot), .active(active), .nar_cmd(ncmd)
  );

  for (genvar j = 0; j < N_PH; j++) begin : g_ncmd
    assign {n_wren[j], n_addr[j*ABITS +: ABITS], n_bank[j*BBITS +: BBITS],
            n_we_n[j], n_cas_n[j], n_ras_n[j], n_cs_n[j]} = ncmd[j*CMDW +: CMDW];
  end

  dfi_rd_wr_pack #(.TOTW(NW*WDW), .WR_DLY(WR_DLY), .CW(CW)) u_wdata (
    .clk(clk), .rst(rst), .tick(slow_tick), .wide_in(w_wrdata),
    .slot(slot), .active(active), .launch(wr_launch), .nar_out(n_wrdata)
  );

  dfi_rd_wr_pack #(.TOTW(NW*WMW), .WR_DLY(WR_DLY), .CW(CW)) u_wmask (
    .clk(clk), .rst(rst), .tick(slow_tick), .wide_in(w_wrmask),
    .slot(slot), .active(active), .launch(mask_launch), .nar_out(n_wrmask)
  );

  dfi_rd_rd_unpack #(
    .N_PH(N_PH), .RATIO(RATIO), .NDW(NDW), .RD_DLY(RD_DLY), .CW(CW)
  ) u_rd (
    .clk(clk), .rst(rst), .tick(slow_tick), .slot(slot), .active(active),
    .nar_data(n_rddata), .nar_valid(n_rdvalid), .grab(rd_grab),
    .wide_data(w_rddata), .wide_valid(w_rdvalid)
  );

  always_ff @(posedge clk) begin
    if (rst)            out_reset_n <= 1'b0;
    else if (slow_tick) out_reset_n <= in_reset_n;
  end
endmodule

// File: rtl/dfi_rate_down_chk.sv
module dfi_rate_down_chk #(
  parameter int N_PH   = 2,
  parameter int RATIO  = 4,
  parameter int NDW    = 32,
  parameter int WR_DLY = 0,
  parameter int CW     = 3,
  localparam int NW    = N_PH * RATIO,
  localparam int WDW   = NDW / RATIO,
  localparam int NMW   = NDW / 8
) (
  input logic                clk,
  input logic                rst,
  input logic                slow_tick,
  input logic [CW-1:0]       slot,
  input logic                active,
  input logic [N_PH-1:0]     n_cs_n,
  input logic [N_PH-1:0]     n_ras_n,
  input logic [N_PH-1:0]     n_cas_n,
  input logic [N_PH-1:0]     n_we_n,
  input logic [N_PH-1:0]     n_wren,
  input logic [N_PH*NDW-1:0] n_wrdata,
  input logic [N_PH*NMW-1:0] n_wrmask,
  input logic [NW*WDW-1:0]   w_rddata,
  input logic [NW-1:0]       w_rdvalid
);
  // R1: a strobe starts slot 0 on the next cycle
  p_strobe_slot0_r1: assert property (@(posedge clk) disable iff (rst)
    slow_tick |=> (active && slot == '0));

  // R2: no active slot means idle control on every narrow phase
  p_idle_ctl_r2: assert property (@(posedge clk) disable iff (rst)
    !active |-> (&n_cs_n && &n_ras_n && &n_cas_n && &n_we_n && n_wren == '0));

  // R5: write data or mask only in the write slot
  p_wr_window_r5: assert property (@(posedge clk) disable iff (rst)
    (n_wrdata != '0 || n_wrmask != '0) |-> (active && slot == CW'(WR_DLY)));

  // R8: wide read outputs frozen unless a strobe came before
  p_rd_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !slow_tick |=> ($stable(w_rddata) && $stable(w_rdvalid)));

  // R10: reset leaves outputs idle
  p_reset_idle_r10: assert property (@(posedge clk)
    rst |=> (&n_cs_n && n_wrdata == '0 && w_rdvalid == '0 && w_rddata == '0));
endmodule

bind dfi_rate_down dfi_rate_down_chk #(
  .N_PH(N_PH), .RATIO(RATIO), .NDW(NDW), .WR_DLY(WR_DLY), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .slow_tick(slow_tick), .slot(slot), .active(active),
  .n_cs_n(n_cs_n), .n_ras_n(n_ras_n), .n_cas_n(n_cas_n), .n_we_n(n_we_n),
  .n_wren(n_wren), .n_wrdata(n_wrdata), .n_wrmask(n_wrmask),
  .w_rddata(w_rddata), .w_rdvalid(w_rdvalid)
);

// File: tb/dfi_rate_down_test.sv
module dfi_rate_down_test;
  localparam int N  = 2;
  localparam int R  = 4;
  localparam int AB = 16;
  localparam int BB = 3;
  localparam int DW = 32;
  localparam int WD = 2;
  localparam int RD = 3;
  localparam int NW = N * R;
  localparam int WDW = DW / R;
  localparam int NMW = DW / 8;
  localparam int WMW = NMW / R;

  logic clk = 0, rst = 1, slow_tick = 0, in_reset_n = 0;
  logic [NW-1:0] w_cs_n, w_ras_n, w_cas_n, w_we_n, w_wren;
  logic [NW*BB-1:0] w_bank;
  logic [NW*AB-1:0] w_addr;
  logic [NW*WDW-1:0] w_wrdata, w_rddata;
  logic [NW*WMW-1:0] w_wrmask;
  logic [NW-1:0] w_rdvalid;
  logic out_reset_n;
  logic [N-1:0] n_cs_n, n_ras_n, n_cas_n, n_we_n, n_wren, n_rdvalid;
  logic [N*BB-1:0] n_bank;
  logic [N*AB-1:0] n_addr;
  logic [N*DW-1:0] n_wrdata, n_rddata;
  logic [N*NMW-1:0] n_wrmask;

  dfi_rate_down #(.N_PH(N), .RATIO(R), .ABITS(AB), .BBITS(BB), .NDW(DW),
                  .WR_DLY(WD), .RD_DLY(RD)) uut (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit cmp_en = 0, done = 0;

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int m_slot;
  logic [NW-1:0] m_cs, m_ras, m_cas, m_we, m_en;
  logic [NW*BB-1:0] m_bank;
  logic [NW*AB-1:0] m_addr;
  logic [NW*WDW-1:0] m_wd;
  logic [NW*WMW-1:0] m_wm;
  logic [N*DW-1:0] m_stage_d, m_out_d;
  logic [N-1:0] m_stage_v, m_out_v;
  logic m_rstn;

  always @(posedge clk) begin
    if (rst) begin
      m_slot = R;
      m_cs = '1; m_ras = '1; m_cas = '1; m_we = '1; m_en = '0;
      m_bank = '0; m_addr = '0; m_wd = '0; m_wm = '0;
      m_stage_d = '0; m_stage_v = '0; m_out_d = '0; m_out_v = '0;
      m_rstn = 0;
    end else begin
      if (slow_tick) begin
        m_out_d = (m_slot == RD) ? n_rddata : m_stage_d;
        m_out_v = (m_slot == RD) ? n_rdvalid : m_stage_v;
      end
      if (m_slot == RD) begin
        m_stage_d = n_rddata;
        m_stage_v = n_rdvalid;
      end
      if (slow_tick) begin
        m_cs = w_cs_n; m_ras = w_ras_n; m_cas = w_cas_n; m_we = w_we_n; m_en = w_wren;
        m_bank = w_bank; m_addr = w_addr; m_wd = w_wrdata; m_wm = w_wrmask;
        m_rstn = in_reset_n;
        m_slot = 0;
      end else if (m_slot < R) m_slot++;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      logic [N-1:0] e_cs, e_ras, e_cas, e_we, e_en;
      logic [N*BB-1:0] e_bank;
      logic [N*AB-1:0] e_addr;
      logic [N*DW-1:0] e_wd;
      logic [N*NMW-1:0] e_wm;
      logic [NW*WDW-1:0] e_rd;
      logic [NW-1:0] e_rv;
      for (int j = 0; j < N; j++) begin
        int k;
        k = m_slot * N + j;
        if (m_slot < R) begin
          e_cs[j] = m_cs[k]; e_ras[j] = m_ras[k]; e_cas[j] = m_cas[k];
          e_we[j] = m_we[k]; e_en[j] = m_en[k];
          e_bank[j*BB +: BB] = m_bank[k*BB +: BB];
          e_addr[j*AB +: AB] = m_addr[k*AB +: AB];
        end else begin
          e_cs[j] = 1; e_ras[j] = 1; e_cas[j] = 1; e_we[j] = 1; e_en[j] = 0;
          e_bank[j*BB +: BB] = '0; e_addr[j*AB +: AB] = '0;
        end
        for (int r = 0; r < R; r++) begin
          e_wd[j*DW + r*WDW +: WDW] = (m_slot == WD) ? m_wd[(j*R + r)*WDW +: WDW] : '0;
          e_wm[j*NMW + r*WMW +: WMW] = (m_slot == WD) ? m_wm[(j*R + r)*WMW +: WMW] : '0;
        end
      end
      for (int p = 0; p < NW; p++) begin
        e_rd[p*WDW +: WDW] = m_out_d[(p / R)*DW + (p % R)*WDW +: WDW];
        e_rv[p] = m_out_v[p / R];
      end
      check({n_cs_n, n_ras_n, n_cas_n, n_we_n, n_wren} == {e_cs, e_ras, e_cas, e_we, e_en},
            "R1/R2 control", {n_cs_n, n_ras_n, n_cas_n, n_we_n, n_wren}, {e_cs, e_ras, e_cas, e_we, e_en});
      check({n_bank, n_addr} == {e_bank, e_addr}, "R1 bank/addr R11", {n_bank, n_addr}, {e_bank, e_addr});
      check(n_wrdata == e_wd, "R3/R5 wrdata", n_wrdata, e_wd);
      check(n_wrmask == e_wm, "R4/R5 wrmask", n_wrmask, e_wm);
      check(w_rddata == e_rd, "R6/R8 rddata", w_rddata, e_rd);
      check(w_rdvalid == e_rv, "R7/R8 rdvalid", w_rdvalid, e_rv);
      check(out_reset_n == m_rstn, "R9 reset_n", out_reset_n, m_rstn);
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive_idle();
    w_cs_n = '1; w_ras_n = '1; w_cas_n = '1; w_we_n = '1; w_wren = '0;
    w_bank = '0; w_addr = '0; w_wrdata = '0; w_wrmask = '0;
    n_rddata = '0; n_rdvalid = '0;
  endtask

  task automatic drive_rand();
    for (int b = 0; b < NW; b++) begin
      w_cs_n[b] = 1'($urandom); w_ras_n[b] = 1'($urandom); w_cas_n[b] = 1'($urandom);
      w_we_n[b] = 1'($urandom); w_wren[b] = 1'($urandom);
      w_bank[b*BB +: BB] = BB'($urandom); w_addr[b*AB +: AB] = AB'($urandom);
      w_wrdata[b*WDW +: WDW] = WDW'($urandom); w_wrmask[b*WMW +: WMW] = WMW'($urandom);
    end
    for (int j = 0; j < N; j++) n_rddata[j*DW +: DW] = $urandom;
    n_rdvalid = N'($urandom);
    in_reset_n = 1'($urandom);
  endtask

  task automatic run_periods(input int cnt, input bit tick_on);
    for (int p = 0; p < cnt; p++)
      for (int i = 0; i < R; i++) begin
        @(negedge clk);
        drive_rand();
        slow_tick = tick_on && (i == R - 1);
      end
  endtask

  initial begin
    drive_idle();
    repeat (3) @(negedge clk);
    check(&n_cs_n && n_wren == '0 && n_wrdata == '0, "R10 reset narrow idle", {n_cs_n, n_wren}, {2'b11, 2'b00});
    check(w_rdvalid == '0 && w_rddata == '0, "R10 reset read zero", {w_rdvalid, w_rddata}, '0);
    check(out_reset_n == 0, "R9 reset level low", out_reset_n, 0);
    rst = 0;
    cmp_en = 1;
    // directed: command on wide phase 7, known data pattern
    @(negedge clk);
    drive_idle();
    w_cs_n[7] = 0; w_cas_n[7] = 0; w_bank[7*BB +: BB] = 3'b111; w_addr[7*AB +: AB] = 16'h0035;
    for (int k = 0; k < NW; k++) w_wrdata[k*WDW +: WDW] = 8'(8'h11 * (k + 1));
    w_wrmask = 8'b0110_1001;
    in_reset_n = 1;
    slow_tick = 1;
    @(negedge clk); slow_tick = 0;                 // slot 0
    check(n_cs_n == 2'b11, "R1 phase7 not in slot0", n_cs_n, 2'b11);
    @(negedge clk); @(negedge clk);                // slot 2 = WD
    check(n_wrdata == 64'h8877665544332211, "R3 packing order", n_wrdata, 64'h8877665544332211);
    check(n_wrmask == 8'b0110_1001, "R4 mask packing", n_wrmask, 8'b0110_1001);
    @(negedge clk);                                // slot 3
    check(n_cs_n == 2'b01 && n_cas_n == 2'b01 && n_addr[AB +: AB] == 16'h0035,
          "R1 phase7 -> slot3 lane1", {n_cs_n, n_addr}, {2'b01, 16'h0035, 16'h0000});
    check(out_reset_n == 1, "R9 reset level passed", out_reset_n, 1);
    @(negedge clk);
    check(&n_cs_n && n_wrdata == '0, "R2 idle after last slot", {n_cs_n, n_wrdata}, {2'b11, 64'h0});
    run_periods(300, 1);
    run_periods(3, 0);        // R2/R11: no strobe, inputs keep changing
    run_periods(300, 1);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule